// File: doc/BRIEF.md
# Glitch-free JTAG source selector

This block lets one external JTAG port reach one of three internal test access ports: the lifecycle TAP, the DFT TAP and the processor debug TAP. Each of these has its own request line. The block picks the winning request by fixed priority and stores the result in three enable flops on the system clock. Each target's TCK and TRST_N are the pad values ANDed with that target's own enable flop. No multiplexer sits in a clock or reset path, so a change of selection can never produce a clock or reset pulse on a target that is not selected.

The TMS and TDI data lines, and the returning TDO and its output enable, pass through an ordinary multiplexer that is steered by the same registered enables. A monitor compares the registered enables with the selection the live requests call for. A difference is expected for one cycle after any request change. A difference that lasts longer raises a fatal alert, which stays set until reset.

Top module: `jtag_tgt_sel`

## Requirements
- R1: While the synchronous active-low reset is applied, all enable flops clear. After reset, every target sees TCK low, TRST_N low, TMS low and TDI low, the pad TDO and its output enable are low, and the fatal alert is low.
- R2: Target i gets TCK = pad TCK AND enable[i], and TRST_N = pad TRST_N AND enable[i]. enable[i] takes its new value at the first rising system-clock edge after the request changes, and not before.
- R3: The selected target's TMS and TDI follow the pad. Every other target sees TMS and TDI at 0.
- R4: The pad TDO and its output enable are copied from the selected target. When no target is selected, both are 0.
- R5: Request bit 0 is the lifecycle target, bit 1 the DFT target and bit 2 the processor debug target. When several requests are active, bit 0 wins over bit 1, and bit 1 wins over bit 2. At most one enable is ever set.
- R6: An unselected target holds TCK and TRST_N low whatever the pad does. Its TCK shows no rising edge while the requests move between targets.
- R7: The monitor tolerates a single cycle in which the enables differ from the selection the live requests call for. If that difference is also present at the next consecutive rising edge, the fatal alert goes high after that edge. A request change that is then held does not set the alert.
- R8: Once set, the fatal alert stays high until reset, even after the requests settle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Synchronous reset, active low |
| req_i | input | 3 | Requests: bit 0 lifecycle, bit 1 DFT, bit 2 processor debug |
| pad_tck_i | input | 1 | External TCK |
| pad_tms_i | input | 1 | External TMS |
| pad_tdi_i | input | 1 | External TDI |
| pad_trst_ni | input | 1 | External TRST_N, active low |
| pad_tdo_o | output | 1 | TDO towards the pad |
| pad_tdo_oe_o | output | 1 | Output enable for the pad TDO |
| tgt_tck_o | output | 3 | Gated TCK, one bit per target |
| tgt_tms_o | output | 3 | TMS, one bit per target |
| tgt_tdi_o | output | 3 | TDI, one bit per target |
| tgt_trst_no | output | 3 | Gated TRST_N, one bit per target |
| tgt_tdo_i | input | 3 | TDO from each target |
| tgt_tdo_oe_i | input | 3 | TDO output enable from each target |
| alert_fatal_o | output | 1 | Sticky fatal alert for a lasting enable/request mismatch |

## Verification
The hardest condition to produce is a selection change that lands while pad TCK is high, because that is where a multiplexed clock would glitch. The bench runs pad TCK from its own free-running source. Its edges are offset so that they never coincide with a system-clock edge. It then steps the requests through every target and through idle while counting rising edges on each target's TCK that occur while a reference model says that target is unselected. The fatal alert cannot be reached by holding requests steady on a correct design. The bench reaches it by changing the requests on two consecutive cycles.

// File: rtl/jtag_sel_pkg.sv
// Package: shared constants and types for the JTAG source selector.
// Assumes exactly three targets. The index of each target is also its priority rank.
package jtag_sel_pkg;
    localparam int unsigned NUM_TGT = 3;
    localparam int unsigned IDX_W   = $clog2(NUM_TGT);
    localparam int unsigned TGT_LC  = 0;
    localparam int unsigned TGT_DFT = 1;
    localparam int unsigned TGT_DBG = 2;

    typedef logic [NUM_TGT-1:0] tgt_vec_t;

    // Returns a vector that keeps only the lowest-index set bit (the highest priority).
    function automatic tgt_vec_t first_set(tgt_vec_t req);
        tgt_vec_t res;
        res = '0;
        for (int i = NUM_TGT - 1; i >= 0; i--) begin
            if (req[i]) begin
                res = '0;
                res[i] = 1'b1;
            end
        end
        return res;
    endfunction
endpackage

// File: rtl/jtag_sel_enable.sv
// Module: jtag_sel_enable
// Resolves the three requests by fixed priority and holds the result in one flop per target.
// Assumes the requests are synchronous to clk_i. want_o is the live, unregistered selection.
module jtag_sel_enable
    import jtag_sel_pkg::*;
(
    input  logic     clk_i,
    input  logic     rst_ni,
    input  tgt_vec_t req_i,
    output tgt_vec_t want_o,
    output tgt_vec_t en_o
);
    tgt_vec_t en_q;

    // Priority resolution of the live requests.
    always_comb want_o = first_set(req_i);

    // One enable flop per target, cleared by reset.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) en_q <= '0;
        else         en_q <= want_o;
    end

    assign en_o = en_q;

    // R5: at most one enable is set.
    assert_onehot_en_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(en_q));

    // R5: a lifecycle request in the previous cycle always wins.
    assert_lc_wins_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(rst_ni && req_i[TGT_LC]) |-> en_q[TGT_LC]);
endmodule

// File: rtl/jtag_sel_gate.sv
// Module: jtag_sel_gate
// Builds each target's TCK and TRST_N from the pad pins and that target's registered enable,
// using plain AND gates and no multiplexer. Assumes en_i comes directly from flops.
module jtag_sel_gate
    import jtag_sel_pkg::*;
(
    input  logic     clk_i,
    input  logic     rst_ni,
    input  tgt_vec_t en_i,
    input  logic     pad_tck_i,
    input  logic     pad_trst_ni,
    output tgt_vec_t tck_o,
    output tgt_vec_t trst_no
);
    for (genvar g = 0; g < NUM_TGT; g++) begin : g_tgt
        // Clock and reset gating for one target.
        assign tck_o[g]   = pad_tck_i   & en_i[g];
        assign trst_no[g] = pad_trst_ni & en_i[g];

        // R6: a disabled target holds TCK and TRST_N low.
        assert_idle_low_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
            !en_i[g] |-> (!tck_o[g] && !trst_no[g]));
    end
endmodule

// File: rtl/jtag_sel_datamux.sv
// Module: jtag_sel_datamux
// Sends TMS and TDI to the selected target and returns that target's TDO to the pad.
// Assumes en_i is one-hot or zero.
module jtag_sel_datamux
    import jtag_sel_pkg::*;
(
    input  logic     clk_i,
    input  logic     rst_ni,
    input  tgt_vec_t en_i,
    input  logic     pad_tms_i,
    input  logic     pad_tdi_i,
    output logic     pad_tdo_o,
    output logic     pad_tdo_oe_o,
    output tgt_vec_t tms_o,
    output tgt_vec_t tdi_o,
    input  tgt_vec_t tdo_i,
    input  tgt_vec_t tdo_oe_i
);
    logic [IDX_W-1:0] sel_idx;
    logic             sel_vld;

    // Encodes the enables into an index and a valid flag.
    always_comb begin
        sel_idx = '0;
        sel_vld = |en_i;
        for (int i = 0; i < NUM_TGT; i++) begin
            if (en_i[i]) sel_idx = IDX_W'(i);
        end
    end

    // Forward multiplexer: only the selected target gets TMS and TDI.
    always_comb begin
        tms_o = '0;
        tdi_o = '0;
        for (int i = 0; i < NUM_TGT; i++) begin
            if (sel_vld && sel_idx == IDX_W'(i)) begin
                tms_o[i] = pad_tms_i;
                tdi_o[i] = pad_tdi_i;
            end
        end
    end

    // Return multiplexer: the selected target's TDO, or 0 when none is selected.
    always_comb begin
        pad_tdo_o    = 1'b0;
        pad_tdo_oe_o = 1'b0;
        if (sel_vld) begin
            pad_tdo_o    = tdo_i[sel_idx];
            pad_tdo_oe_o = tdo_oe_i[sel_idx];
        end
    end

    // R4: with no selection, TDO and its output enable are 0.
    assert_tdo_idle_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en_i == '0) |-> (!pad_tdo_o && !pad_tdo_oe_o));

    // R3: with no selection, no target gets TMS or TDI.
    assert_data_idle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en_i == '0) |-> (tms_o == '0 && tdi_o == '0));
endmodule

// File: rtl/jtag_sel_monitor.sv
// Module: jtag_sel_monitor
// Counts consecutive cycles in which the registered enables differ from the live selection.
// Raises a sticky fatal alert once the count passes MAX_MISMATCH. Assumes MAX_MISMATCH >= 1.
module jtag_sel_monitor
    import jtag_sel_pkg::*;
#(
    parameter int unsigned MAX_MISMATCH = 1
) (
    input  logic     clk_i,
    input  logic     rst_ni,
    input  tgt_vec_t en_i,
    input  tgt_vec_t want_i,
    output logic     alert_o
);
    localparam int unsigned CNT_W = $clog2(MAX_MISMATCH + 2);
    localparam logic [CNT_W-1:0] CNT_LIM = CNT_W'(MAX_MISMATCH);

    logic             mismatch;
    logic [CNT_W-1:0] cnt_q;
    logic             alert_q;

    // Compares the flop contents with the selection the live requests call for.
    assign mismatch = (en_i != want_i);

    // Counts consecutive mismatch cycles, saturating at the limit.
    always_ff @(posedge clk_i) begin
        if (!rst_ni)          cnt_q <= '0;
        else if (!mismatch)   cnt_q <= '0;
        else if (cnt_q < CNT_LIM) cnt_q <= cnt_q + 1'b1;
    end

    // Sticky fatal alert.
    always_ff @(posedge clk_i) begin
        if (!rst_ni)                        alert_q <= 1'b0;
        else if (mismatch && cnt_q >= CNT_LIM) alert_q <= 1'b1;
    end

    assign alert_o = alert_q;

    // R8: the alert never clears without reset.
    assert_alert_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        alert_q |=> alert_q);

    // R7: the alert only rises after a mismatch was present.
    assert_alert_cause_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(alert_q) |-> $past(mismatch));
endmodule

// File: rtl/jtag_tgt_sel.sv
// Module: jtag_tgt_sel (top)
// Routes one external JTAG port to the lifecycle, DFT or processor debug TAP.
// Clock and reset use AND gating with registered enables. Data uses a multiplexer.
// Assumes the requests are synchronous to clk_i and the reset is synchronous and active low.
module jtag_tgt_sel
    import jtag_sel_pkg::*;
#(
    parameter int unsigned MAX_MISMATCH = 1
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [NUM_TGT-1:0] req_i,
    input  logic               pad_tck_i,
    input  logic               pad_tms_i,
    input  logic               pad_tdi_i,
    input  logic               pad_trst_ni,
    output logic               pad_tdo_o,
    output logic               pad_tdo_oe_o,
    output logic [NUM_TGT-1:0] tgt_tck_o,
    output logic [NUM_TGT-1:0] tgt_tms_o,
    output logic [NUM_TGT-1:0] tgt_tdi_o,
    output logic [NUM_TGT-1:0] tgt_trst_no,
    input  logic [NUM_TGT-1:0] tgt_tdo_i,
    input  logic [NUM_TGT-1:0] tgt_tdo_oe_i,
    output logic               alert_fatal_o
);
    tgt_vec_t want;
    tgt_vec_t en;

    jtag_sel_enable u_enable (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .req_i  (req_i),
        .want_o (want),
        .en_o   (en)
    );

    jtag_sel_gate u_gate (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .en_i        (en),
        .pad_tck_i   (pad_tck_i),
        .pad_trst_ni (pad_trst_ni),
        .tck_o       (tgt_tck_o),
        .trst_no     (tgt_trst_no)
    );

    jtag_sel_datamux u_datamux (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .en_i         (en),
        .pad_tms_i    (pad_tms_i),
        .pad_tdi_i    (pad_tdi_i),
        .pad_tdo_o    (pad_tdo_o),
        .pad_tdo_oe_o (pad_tdo_oe_o),
        .tms_o        (tgt_tms_o),
        .tdi_o        (tgt_tdi_o),
        .tdo_i        (tgt_tdo_i),
        .tdo_oe_i     (tgt_tdo_oe_i)
    );

    jtag_sel_monitor #(
        .MAX_MISMATCH (MAX_MISMATCH)
    ) u_monitor (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .en_i    (en),
        .want_i  (want),
        .alert_o (alert_fatal_o)
    );
endmodule

// File: tb/jtag_tgt_sel_test.sv
`timescale 1ns/1ps
// Directed bench for jtag_tgt_sel. Each task drives one scenario and checks its own results.
module jtag_tgt_sel_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] req = '0;
    logic       tck = 1'b0, tms = 1'b0, tdi = 1'b0, trst_n = 1'b0;
    logic       tdo, tdo_oe;
    logic [2:0] t_tck, t_tms, t_tdi, t_trst_n;
    logic [2:0] t_tdo = '0, t_tdo_oe = '0;
    logic       alert;

    int  n_chk = 0;
    int  n_fail = 0;
    int  glitches = 0;
    bit  free_tck = 1'b0;
    bit  done = 1'b0;
    logic [2:0] exp_en = '0;

    always #5 clk = ~clk;

    jtag_tgt_sel uut (
        .clk_i(clk), .rst_ni(rst_n), .req_i(req),
        .pad_tck_i(tck), .pad_tms_i(tms), .pad_tdi_i(tdi), .pad_trst_ni(trst_n),
        .pad_tdo_o(tdo), .pad_tdo_oe_o(tdo_oe),
        .tgt_tck_o(t_tck), .tgt_tms_o(t_tms), .tgt_tdi_o(t_tdi), .tgt_trst_no(t_trst_n),
        .tgt_tdo_i(t_tdo), .tgt_tdo_oe_i(t_tdo_oe), .alert_fatal_o(alert)
    );

    // Reference selection from the priority rule: bit 0 beats bit 1, bit 1 beats bit 2.
    function automatic logic [2:0] ref_pick(logic [2:0] r);
        if (r[0]) return 3'b001;
        if (r[1]) return 3'b010;
        if (r[2]) return 3'b100;
        return 3'b000;
    endfunction

    // Reference enables: take the new value at each rising system-clock edge.
    always @(posedge clk) exp_en <= rst_n ? ref_pick(req) : 3'b000;

    // Free-running pad TCK with edges offset from every system-clock edge.
    initial begin
        #0.3;
        forever begin
            #7;
            if (free_tck) tck = ~tck;
        end
    end

    // Counts TCK rising edges on targets the reference says are unselected (R6).
    for (genvar g = 0; g < 3; g++) begin : g_mon
        always @(posedge t_tck[g]) begin
            #0.001;
            if (!exp_en[g]) glitches++;
        end
    end

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp,
                       input string what);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        cycles(3);
        rst_n = 1'b1;
        cycles(1);
    endtask

    task automatic t_reset();
        tck = 1'b1; trst_n = 1'b1; tms = 1'b1; tdi = 1'b1;
        t_tdo = 3'b111; t_tdo_oe = 3'b111;
        #1;
        chk("R1", t_tck, 0, "tck after reset");
        chk("R1", t_trst_n, 0, "trst_n after reset");
        chk("R1", {t_tms, t_tdi}, 0, "tms/tdi after reset");
        chk("R1", {tdo, tdo_oe}, 0, "tdo/oe after reset");
        chk("R1", alert, 0, "alert after reset");
    endtask

    task automatic t_single(input int k);
        logic [2:0] oh;
        oh = 3'b001 << k;
        @(negedge clk);
        req = oh;
        cycles(2);
        tck = 1'b1; trst_n = 1'b1; tms = 1'b1; tdi = 1'b0;
        t_tdo = oh; t_tdo_oe = oh;
        #1;
        chk("R2", t_tck, oh, "tck gated to selected");
        chk("R2", t_trst_n, oh, "trst_n gated to selected");
        chk("R3", t_tms, oh, "tms to selected only");
        tms = 1'b0; tdi = 1'b1;
        #1;
        chk("R3", {t_tms, t_tdi}, {3'b000, oh}, "tdi to selected only");
        chk("R4", {tdo, tdo_oe}, 2'b11, "tdo from selected");
        t_tdo = ~oh;
        #1;
        chk("R4", tdo, 0, "tdo ignores unselected");
        tck = 1'b0; trst_n = 1'b0;
        #1;
        chk("R2", t_tck | t_trst_n, 0, "pad low reaches target");
    endtask

    task automatic t_priority();
        tck = 1'b1; trst_n = 1'b1;
        req = 3'b111; cycles(2);
        chk("R5", t_tck, 3'b001, "lifecycle beats all");
        req = 3'b110; cycles(2);
        chk("R5", t_tck, 3'b010, "dft beats debug");
        req = 3'b101; cycles(2);
        chk("R5", t_tck, 3'b001, "lifecycle beats debug");
        req = 3'b000; cycles(2);
        chk("R6", t_tck | t_trst_n, 0, "idle holds all low");
        t_tdo = 3'b111; t_tdo_oe = 3'b111;
        #1;
        chk("R4", {tdo, tdo_oe}, 0, "no selection tdo idle");
    endtask

    task automatic t_lag();
        tck = 1'b1; trst_n = 1'b1;
        req = 3'b100; cycles(3);
        req = 3'b010;
        #1;
        chk("R2", t_tck, 3'b100, "old enable before edge");
        cycles(1);
        chk("R2", t_tck, 3'b010, "new enable after edge");
        cycles(3);
        chk("R7", alert, 0, "single change no alert");
        req = 3'b000; cycles(3);
    endtask

    task automatic t_glitch();
        free_tck = 1'b1;
        trst_n = 1'b1;
        glitches = 0;
        for (int s = 0; s < 40; s++) begin
            req = 3'((s * 5 + 3) % 8);
            cycles(3 + (s % 3));
        end
        req = 3'b000;
        cycles(3);
        free_tck = 1'b0;
        tck = 1'b0;
        chk("R6", glitches, 0, "tck edges on unselected targets");
        chk("R7", alert, 0, "held changes never alert");
    endtask

    task automatic t_alert();
        req = 3'b000; cycles(2);
        req = 3'b001; cycles(1);
        req = 3'b010; cycles(1);
        chk("R7", alert, 1, "two consecutive mismatches alert");
        cycles(6);
        chk("R8", alert, 1, "alert sticky after settle");
        req = 3'b000;
        do_reset();
        chk("R8", alert, 0, "reset clears alert");
    endtask

    initial begin
        cycles(1);
        do_reset();
        t_reset();
        for (int k = 0; k < 3; k++) t_single(k);
        t_priority();
        t_lag();
        t_glitch();
        t_alert();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        end
        $finish;
    end

    initial begin
        #1_000_000;
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        end
        $finish;
    end
endmodule